// File: doc/BRIEF.md
# IEEE 1284 Mode Negotiation and Termination Sequencer

This block sits on the host side of a parallel-port link. It moves the link out of compatibility mode into a requested IEEE 1284 mode, and it brings the link back to compatibility mode when asked. It drives the four host control lines and the eight data lines. It watches the five peripheral status lines. Every wait is bounded by a timeout counted in programmable time units.

A controller issues a one-cycle negotiation command that carries an 8-bit extensibility code, or a one-cycle termination command. The block runs the numbered event sequence for that command. It then posts a result code and pulses `done`. The pin state it leaves behind is held until the next command. Code 0x00 asks for nibble mode, which a 1284 peripheral may not refuse. Any code with bit 4 set is taken as an ECP request and gets an extra setup step. The usual reverse-capable request is 0x30, which is ECP with run-length encoding.

Status inputs are assumed to be already synchronous to `clk`. A time unit lasts `tick_div` clock cycles, and a value of 0 is treated as 1. Result codes are: 0 success, 1 timeout, 2 I/O error, 3 mode unsupported, 4 rejected. Link modes are: 0 compatibility, 1 nibble, 2 ECP, 3 other extended mode.

Top module: `p1284_negotiator`

## Requirements
- R1: After reset the lines rest in compatibility idle: `h_strobe_n`=1, `h_autofd_n`=1, `h_selin`=0, `h_init_n`=1. Also `h_data`=0, `busy`=0, `done`=0 and `link_mode`=0.
- R2: A negotiation command that arrives while `h_selin` is high changes no pin and never raises `busy`. On the next clock edge the block pulses `done` with result 4.
- R3: On a negotiation command the code appears on `h_data` at the next edge. `h_selin` rises exactly one time unit after that (edge 1+T after the command).
- R4: Event 1: `h_selin`=1 and `h_autofd_n`=0, while `h_strobe_n` and `h_init_n` stay 1. If the condition PError=1, Select=1, nFault=1 and nAck=0 is not met within 6 units, the block posts result 1 (done at edge 1+7T).
- R5: When that condition is seen, `h_strobe_n` goes low for exactly one unit. Then `h_strobe_n` and `h_autofd_n` both go high, and nAck must go high within 7 units. If it does not, the block posts result 2 (done at edge 2+9T).
- R6: Code 0x00 is accepted whatever the level of Select: result 0, `link_mode`=1, done at edge 2T+3 when the peripheral answers at once.
- R7: A nonzero code is refused when Select is low in the cycle that nAck is seen high. The block then posts result 3 and `link_mode` stays 0.
- R8: An accepted code with bit 4 set drives `h_autofd_n` low and waits up to 6 units for PError high. Success gives result 0 with `link_mode`=2; a timeout gives result 1. An accepted nonzero code with bit 4 clear gives result 0 with `link_mode`=3.
- R9: Termination drives `h_selin`=0 with `h_autofd_n`, `h_strobe_n` and `h_init_n` at 1. If Busy=1, nFault=1 and nAck=0 do not all appear within 7 units, the block posts result 2 (done at edge 1+7T).
- R10: After that acknowledgment `h_autofd_n` goes low until nAck is high, for at most 6 units. `h_autofd_n` is high again when `done` is posted, both on success (result 0) and on timeout (result 2).
- R11: Every termination, successful or not, ends with `link_mode`=0.
- R12: `busy` is high from the edge after an accepted command until the edge that posts the result. `done` lasts one cycle. Commands that arrive while `busy` is high have no effect.
- R13: A time unit is `tick_div` cycles, and 0 counts as 1. The unit count restarts on entry to each step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_div | input | PRE_W | Clock cycles per time unit (0 treated as 1) |
| neg_start | input | 1 | One-cycle negotiation command |
| neg_code | input | 8 | Extensibility code to request |
| term_start | input | 1 | One-cycle termination command |
| p_ack_n | input | 1 | Peripheral nAck |
| p_busy | input | 1 | Peripheral Busy |
| p_perror | input | 1 | Peripheral PError |
| p_select | input | 1 | Peripheral Select |
| p_fault_n | input | 1 | Peripheral nFault |
| h_strobe_n | output | 1 | Host nStrobe |
| h_autofd_n | output | 1 | Host nAutoFd |
| h_selin | output | 1 | Host nSelectIn line level |
| h_init_n | output | 1 | Host nInit |
| h_data | output | 8 | Data lines |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle result strobe |
| result | output | 3 | Result code |
| link_mode | output | 2 | Current link mode |

## Verification
The run is repeated for each time-unit setting 0, 1, 2, 3 and 5, so that every timeout and fixed delay can be checked against its arithmetic cycle count. A behavioral peripheral answers in one of several ways:
- not at all, which tells the event-1 timeout apart from the event-6 timeout;
- with Select low or high under codes 0x00, 0x30 and 0x08, which separates forced nibble acceptance, refusal and the ECP and other-mode outcomes;
- with PError withdrawn, which exercises the ECP setup timeout.

Terminations run with no answer, with a full answer, and with the second acknowledgment missing. A redundant negotiation while the link is held selected checks the reject path, and a stray command pulse during a wait checks that commands are ignored while busy.

// File: rtl/p1284_negotiator.sv
`timescale 1ns/1ps
module p1284_negotiator #(
  parameter int PRE_W   = 8,
  parameter int SETUP_U = 1,
  parameter int RESP_U  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRE_W-1:0] tick_div,
  input  logic             neg_start,
  input  logic [7:0]       neg_code,
  input  logic             term_start,
  input  logic             p_ack_n,
  input  logic             p_busy,
  input  logic             p_perror,
  input  logic             p_select,
  input  logic             p_fault_n,
  output logic             h_strobe_n,
  output logic             h_autofd_n,
  output logic             h_selin,
  output logic             h_init_n,
  output logic [7:0]       h_data,
  output logic             busy,
  output logic             done,
  output logic [2:0]       result,
  output logic [1:0]       link_mode
);
  localparam int LIM_W = $clog2(SETUP_U + RESP_U + 1);
  localparam logic [LIM_W-1:0] RESP_LAST = LIM_W'(RESP_U - 1);
  localparam logic [LIM_W-1:0] ACK_LAST  = LIM_W'(SETUP_U + RESP_U - 1);

  localparam logic [3:0] S_IDLE = 4'd0, S_SETUP = 4'd1, S_EV1 = 4'd2, S_STRB = 4'd3,
                         S_EV6 = 4'd4, S_ECP = 4'd5, S_T22 = 4'd6, S_T25 = 4'd7;
  localparam logic [2:0] R_OK = 3'd0, R_TMO = 3'd1, R_IOE = 3'd2, R_UNS = 3'd3, R_REJ = 3'd4;
  localparam logic [1:0] M_CMP = 2'd0, M_NIB = 2'd1, M_ECP = 2'd2, M_OTH = 2'd3;

  logic [3:0]       st;
  logic [PRE_W-1:0] pre;
  logic [LIM_W-1:0] units;

  wire [PRE_W-1:0] pre_last = (tick_div == '0) ? '0 : tick_div - 1'b1;
  wire tick     = (pre == pre_last);
  wire ev2_ok   = p_perror && p_select && p_fault_n && !p_ack_n;
  wire ev23_ok  = p_busy && p_fault_n && !p_ack_n;
  wire resp_end = tick && (units == RESP_LAST);
  wire ack_end  = tick && (units == ACK_LAST);

  assign busy     = (st != S_IDLE);
  assign h_init_n = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; pre <= '0; units <= '0;
      h_strobe_n <= 1'b1; h_autofd_n <= 1'b1; h_selin <= 1'b0; h_data <= '0;
      done <= 1'b0; result <= R_OK; link_mode <= M_CMP;
    end else begin
      done <= 1'b0;
      if (tick) begin
        pre <= '0;
        units <= units + 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
      case (st)
        S_IDLE: begin
          pre <= '0; units <= '0;
          if (neg_start) begin
            if (h_selin) begin
              done <= 1'b1; result <= R_REJ;
            end else begin
              h_data <= neg_code; st <= S_SETUP;
            end
          end else if (term_start) begin
            h_selin <= 1'b0; h_autofd_n <= 1'b1; h_strobe_n <= 1'b1; st <= S_T22;
          end
        end
        S_SETUP: if (tick) begin
          h_selin <= 1'b1; h_autofd_n <= 1'b0; st <= S_EV1; pre <= '0; units <= '0;
        end
        S_EV1: begin
          if (ev2_ok) begin
            h_strobe_n <= 1'b0; st <= S_STRB; pre <= '0; units <= '0;
          end else if (resp_end) begin
            st <= S_IDLE; done <= 1'b1; result <= R_TMO;
          end
        end
        S_STRB: if (tick) begin
          h_strobe_n <= 1'b1; h_autofd_n <= 1'b1; st <= S_EV6; pre <= '0; units <= '0;
        end
        S_EV6: begin
          if (p_ack_n) begin
            if (h_data == 8'h00) begin
              st <= S_IDLE; done <= 1'b1; result <= R_OK; link_mode <= M_NIB;
            end else if (!p_select) begin
              st <= S_IDLE; done <= 1'b1; result <= R_UNS;
            end else if (h_data[4]) begin
              h_autofd_n <= 1'b0; st <= S_ECP; pre <= '0; units <= '0;
            end else begin
              st <= S_IDLE; done <= 1'b1; result <= R_OK; link_mode <= M_OTH;
            end
          end else if (ack_end) begin
            st <= S_IDLE; done <= 1'b1; result <= R_IOE;
          end
        end
        S_ECP: begin
          if (p_perror) begin
            st <= S_IDLE; done <= 1'b1; result <= R_OK; link_mode <= M_ECP;
          end else if (resp_end) begin
            st <= S_IDLE; done <= 1'b1; result <= R_TMO;
          end
        end
        S_T22: begin
          if (ev23_ok) begin
            h_autofd_n <= 1'b0; st <= S_T25; pre <= '0; units <= '0;
          end else if (ack_end) begin
            st <= S_IDLE; done <= 1'b1; result <= R_IOE; link_mode <= M_CMP;
          end
        end
        S_T25: begin
          if (p_ack_n) begin
            h_autofd_n <= 1'b1; st <= S_IDLE; done <= 1'b1; result <= R_OK; link_mode <= M_CMP;
          end else if (resp_end) begin
            h_autofd_n <= 1'b1; st <= S_IDLE; done <= 1'b1; result <= R_IOE; link_mode <= M_CMP;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/p1284_negotiator_chk.sv
`timescale 1ns/1ps
module p1284_negotiator_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] st,
  input logic       busy,
  input logic       done,
  input logic [2:0] result,
  input logic [1:0] link_mode,
  input logic       h_selin,
  input logic       h_autofd_n,
  input logic       h_strobe_n,
  input logic [7:0] h_data
);
  a_r4_ev1_pins: assert property (@(posedge clk) disable iff (!rst_n)
    st == 4'd2 |-> h_selin && !h_autofd_n && h_strobe_n);
  a_r5_strobe_window: assert property (@(posedge clk) disable iff (!rst_n)
    !h_strobe_n |-> st == 4'd3);
  a_r3_setup_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
    st == 4'd1 |-> !h_selin && h_strobe_n);
  a_r2_reject: assert property (@(posedge clk) disable iff (!rst_n)
    done && result == 3'd4 |-> h_selin && !$past(busy));
  a_r6_nibble_code: assert property (@(posedge clk) disable iff (!rst_n)
    done && result == 3'd0 && link_mode == 2'd1 |-> h_data == 8'h00);
  a_r7_unsup_compat: assert property (@(posedge clk) disable iff (!rst_n)
    done && result == 3'd3 |-> link_mode == 2'd0);
  a_r10_autofd_back: assert property (@(posedge clk) disable iff (!rst_n)
    done && $past(st) == 4'd7 |-> h_autofd_n);
  a_r11_term_compat: assert property (@(posedge clk) disable iff (!rst_n)
    done && ($past(st) == 4'd6 || $past(st) == 4'd7) |-> link_mode == 2'd0 && !h_selin);
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r12_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
endmodule

bind p1284_negotiator p1284_negotiator_chk u_chk (.*);

// File: tb/p1284_negotiator_tb.sv
`timescale 1ns/1ps
module p1284_negotiator_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] tick_div = 8'd1;
  logic neg_start = 1'b0, term_start = 1'b0;
  logic [7:0] neg_code = 8'h00;
  logic p_ack_n = 1'b1, p_busy = 1'b0, p_perror = 1'b0, p_select = 1'b0, p_fault_n = 1'b1;
  logic h_strobe_n, h_autofd_n, h_selin, h_init_n, busy, done;
  logic [7:0] h_data;
  logic [2:0] result;
  logic [1:0] link_mode;

  int checks = 0, errors = 0;
  bit m_ev2, m_ev6, m_ecp_perr, m_sel, m_term, m_term_ack;
  int ph, tph;
  int g_n, g_res, g_slo, g_alo, g_first_sel, g_busy_bad;

  always #2 clk = ~clk;

  p1284_negotiator u_dut (.*);

  initial begin
    #400us;
    errors++;
    $display("FAIL watchdog: run did not end (actual hung, expected finished)");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic per_reset();
    p_ack_n = 1'b1; p_busy = 1'b0; p_perror = 1'b0; p_select = 1'b0; p_fault_n = 1'b1;
    ph = 0; tph = 0;
  endtask

  task automatic periph_step();
    if (m_ev2 && ph == 0 && h_selin && !h_autofd_n && h_strobe_n) begin
      p_perror = 1'b1; p_select = 1'b1; p_fault_n = 1'b1; p_ack_n = 1'b0; ph = 1;
    end else if (ph == 1 && !h_strobe_n) ph = 2;
    else if (ph == 2 && h_strobe_n && h_autofd_n) begin
      if (m_ev6) p_ack_n = 1'b1;
      p_select = m_sel; p_perror = m_ecp_perr; ph = 3;
    end
    if (m_term && tph == 0 && !h_selin && h_autofd_n) begin
      p_busy = 1'b1; p_fault_n = 1'b1; p_ack_n = 1'b0; tph = 1;
    end else if (tph == 1 && !h_autofd_n) begin
      if (m_term_ack) p_ack_n = 1'b1;
      tph = 2;
    end
  endtask

  task automatic run_op(input bit do_neg, input logic [7:0] code, input int ign_at);
    per_reset();
    g_n = 0; g_slo = 0; g_alo = 0; g_first_sel = -1; g_busy_bad = 0;
    @(negedge clk);
    neg_code = code; neg_start = do_neg; term_start = !do_neg;
    do begin
      @(posedge clk);
      g_n++;
      @(negedge clk);
      neg_start = 1'b0; term_start = 1'b0;
      if (g_n == ign_at) begin neg_start = 1'b1; term_start = 1'b1; neg_code = 8'h00; end
      if (!h_strobe_n) g_slo++;
      if (!h_autofd_n && !done) g_alo++;
      if (h_selin && g_first_sel < 0) g_first_sel = g_n;
      if (!done && !busy) g_busy_bad++;
      periph_step();
    end while (!done && g_n < 3000);
    neg_start = 1'b0; term_start = 1'b0;
    g_res = done ? int'(result) : -1;
  endtask

  task automatic term_ok();
    m_term = 1; m_term_ack = 1;
    run_op(0, 8'h00, 0);
    chk("R11 term result", g_res, 0);
    chk("R11 term mode", link_mode, 0);
    m_term = 0;
  endtask

  initial begin
    int tdv[5] = '{0, 1, 2, 3, 5};
    for (int k = 0; k < 5; k++) begin
      int T;
      T = (tdv[k] == 0) ? 1 : tdv[k];
      rst_n = 1'b0; tick_div = 8'(tdv[k]);
      m_ev2 = 0; m_ev6 = 0; m_ecp_perr = 0; m_sel = 0; m_term = 0; m_term_ack = 0;
      per_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle pins", {h_strobe_n, h_autofd_n, h_selin, h_init_n}, 4'b1101);
      chk("R1 busy/done/mode/data", {busy, done, link_mode, h_data}, 0);

      // R4/R13: no answer at event 1, stray command at cycle 2 ignored (R12)
      run_op(1, 8'h30, 2);
      chk("R4 timeout result", g_res, 1);
      chk("R13 R4 timeout edges", g_n, 1 + 7*T);
      chk("R3 selin rise edge", g_first_sel, 1 + T);
      chk("R3 data lines", h_data, 8'h30);
      chk("R4 pins held", {h_strobe_n, h_autofd_n, h_selin}, 3'b101);
      chk("R12 busy during op", g_busy_bad, 0);

      // R2: reject while selin high
      run_op(1, 8'h00, 0);
      chk("R2 reject result", g_res, 4);
      chk("R2 reject latency", g_n, 1);
      chk("R2 pins unchanged", {h_strobe_n, h_autofd_n, h_selin, h_data}, {3'b101, 8'h30});

      // R9: termination, no answer
      run_op(0, 8'h00, 0);
      chk("R9 result", g_res, 2);
      chk("R9 edges", g_n, 1 + 7*T);
      chk("R11 mode after fail", link_mode, 0);
      chk("R9 pins", {h_strobe_n, h_autofd_n, h_selin}, 3'b110);

      // R5/R6: nibble, Select low still accepted
      m_ev2 = 1; m_ev6 = 1; m_sel = 0; m_ecp_perr = 1;
      run_op(1, 8'h00, 0);
      chk("R6 result", g_res, 0);
      chk("R6 mode", link_mode, 1);
      chk("R6 edges", g_n, 2*T + 3);
      chk("R5 strobe low width", g_slo, T);
      chk("R12 busy during op", g_busy_bad, 0);
      term_ok();
      chk("R10 autofd low cycles", g_alo, 1);
      chk("R10 edges", g_n, 3);
      chk("R10 pins", {h_strobe_n, h_autofd_n, h_selin}, 3'b110);

      // R8: ECP accepted
      m_sel = 1; m_ecp_perr = 1;
      run_op(1, 8'h30, 0);
      chk("R8 ecp result", g_res, 0);
      chk("R8 ecp mode", link_mode, 2);
      chk("R8 ecp edges", g_n, 2*T + 4);
      chk("R8 autofd low held", h_autofd_n, 0);
      term_ok();

      // R7: nonzero code, Select low
      m_sel = 0;
      run_op(1, 8'h30, 0);
      chk("R7 result", g_res, 3);
      chk("R7 mode", link_mode, 0);
      chk("R7 edges", g_n, 2*T + 3);
      term_ok();

      // R8: other mode
      m_sel = 1;
      run_op(1, 8'h08, 0);
      chk("R8 other result", g_res, 0);
      chk("R8 other mode", link_mode, 3);
      term_ok();

      // R8: ECP setup timeout, then R10 second-ack timeout
      m_ecp_perr = 0;
      run_op(1, 8'h30, 0);
      chk("R8 ecp timeout result", g_res, 1);
      chk("R8 ecp timeout edges", g_n, 2*T + 3 + 6*T);
      m_term = 1; m_term_ack = 0;
      run_op(0, 8'h00, 0);
      chk("R10 timeout result", g_res, 2);
      chk("R10 timeout edges", g_n, 2 + 6*T);
      chk("R10 autofd restored", h_autofd_n, 1);
      chk("R11 mode after timeout", link_mode, 0);
      m_term = 0;

      // R5: event 6 never comes
      m_ev6 = 0; m_ecp_perr = 1;
      run_op(1, 8'h00, 0);
      chk("R5 ev6 timeout result", g_res, 2);
      chk("R5 ev6 timeout edges", g_n, 2 + 9*T);
      term_ok();
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule